// File: doc/BRIEF.md
# Multichannel Prescaled PWM Controller

This block generates several independent pulse-width-modulated outputs from one clock. Each channel has four registers that software reaches over a small memory-mapped bus with separate read and write strobes. A channel divides the clock by a programmable prescale factor to form counter steps. It counts a programmable number of steps per period and drives its output high for a programmable number of steps at the start of each period.

Reprogramming never produces a torn waveform. Writes to the prescale and period registers are only staged. A write to the high-time register captures the staged prescale, the staged period and the new high time as one pending set. The pending set replaces the running settings at the moment the current period ends. If another high-time write arrives before then, it replaces the pending set. Clearing the run bit is the exception: the output drops and the counters restart on the next clock.

Each channel owns a 32-byte register window. The channel index sits in the address bits above bit 4, and the register offset sits in bits 4:0.

Top module: `mpwm_ctrl`

## Requirements
- R1: Channel c's window starts at byte address c*32. Within the window, DIV is at offset 0x00 and holds bits [7:0]; TOP is at 0x04 and holds bits [7:0]; HIGH is at 0x08 and holds bits [15:0]; RUN is at 0x18 and holds bit 0. Higher write-data bits are dropped. A read strobe returns the register contents, zero-extended to 32 bits, on `bus_rdata` one cycle later.
- R2: Some accesses are unmapped: any other offset, or a channel index of NUM_CH or more. Reads of an unmapped address return zero, and writes to it change no channel's registers or output.
- R3: Once RUN is set, the output of the new period starts in the cycle after the RUN write, at step 0. Each step lasts DIV+1 clocks. A period is TOP steps long, and the output is high during the first HIGH steps of each period.
- R4: Writing DIV or TOP without a later HIGH write leaves the output waveform unchanged.
- R5: A HIGH write commits {staged DIV, staged TOP, written HIGH} as one pending set. The running period completes with the old settings, and the next period uses the new set, including the new prescale.
- R6: A second HIGH write before the period boundary replaces the pending set. Only the latest set is ever applied.
- R7: Writing 0 to RUN forces the output low from the cycle after the write, without finishing the period. A later enable restarts from step 0.
- R8: While RUN is 0, the output stays low. A commit made while disabled is in force from the very first period after enabling.
- R9: When HIGH >= TOP (with TOP > 0), the output is constantly high while running. When HIGH is 0, it stays constantly low.
- R10: When TOP is 0, the output stays low and the step count does not advance. In that state, every DIV+1 clocks counts as a period boundary for applying a pending set.
- R11: After reset, all registers and running settings are zero, every output is low, and reads return zero.
- R12: Channels are independent. Programming or running one channel does not alter another channel's output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the bus and all counters |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | ADDR_W (8) | Byte address: channel index in bits above 4, register offset in bits 4:0 |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_re | input | 1 | Read strobe; data appears one cycle later |
| bus_rdata | output | DATA_W (32) | Read data, zero-extended register contents |
| pwm_out | output | NUM_CH (4) | One PWM output per channel, active high |

## Verification
Some properties are checked on every cycle:
- a disabled channel never drives high;
- a run-clear write forces the output low on the next cycle;
- outputs are quiet when reset is released;
- read data is zero above the register width, and zero for unmapped addresses.

The bench's directed scenarios cover what needs a known history of writes. These include the exact step and period timing under several prescale values, and the point where a pending set takes over. They also cover replacement of a pending set by a second commit, staging writes that must have no effect, the saturated and zero duty cases, and the zero-period boundary rule.

// File: rtl/mpwm_pkg.sv
package mpwm_pkg;

   // Each channel window is 2**WIN_SHIFT bytes wide.
   localparam int unsigned WIN_SHIFT = 5;

   localparam logic [WIN_SHIFT-1:0] OFS_DIV  = 5'h00;
   localparam logic [WIN_SHIFT-1:0] OFS_TOP  = 5'h04;
   localparam logic [WIN_SHIFT-1:0] OFS_HIGH = 5'h08;
   localparam logic [WIN_SHIFT-1:0] OFS_RUN  = 5'h18;

   typedef enum logic [2:0] {
      SEL_NONE = 3'd0,
      SEL_DIV  = 3'd1,
      SEL_TOP  = 3'd2,
      SEL_HIGH = 3'd3,
      SEL_RUN  = 3'd4
   } reg_sel_e;

   function automatic reg_sel_e decode_ofs(input logic [WIN_SHIFT-1:0] ofs);
      case (ofs)
         OFS_DIV:  return SEL_DIV;
         OFS_TOP:  return SEL_TOP;
         OFS_HIGH: return SEL_HIGH;
         OFS_RUN:  return SEL_RUN;
         default:  return SEL_NONE;
      endcase
   endfunction

endpackage

// File: rtl/mpwm_addr_dec.sv
module mpwm_addr_dec
   import mpwm_pkg::*;
#(
   parameter int NUM_CH   = 4,
   parameter int ADDR_W   = 8,
   parameter int CH_IDX_W = 2
) (
   input  logic [ADDR_W-1:0]   addr,
   input  logic                we,
   output logic [NUM_CH-1:0]   ch_we,
   output logic [CH_IDX_W-1:0] ch_idx,
   output reg_sel_e            sel,
   output logic                hit
);
   localparam int HI_W = ADDR_W - WIN_SHIFT;

   logic [HI_W-1:0] win;
   reg_sel_e        sel_raw;
   logic            win_ok;

   assign win     = addr[ADDR_W-1:WIN_SHIFT];
   assign sel_raw = decode_ofs(addr[WIN_SHIFT-1:0]);
   assign win_ok  = (32'(win) < NUM_CH);
   assign hit     = win_ok && (sel_raw != SEL_NONE);
   assign sel     = hit ? sel_raw : SEL_NONE;
   assign ch_idx  = win[CH_IDX_W-1:0];

   for (genvar c = 0; c < NUM_CH; c++) begin : g_we
      assign ch_we[c] = we && hit && (32'(win) == c);
   end

endmodule

// File: rtl/mpwm_chan_regs.sv
module mpwm_chan_regs
   import mpwm_pkg::*;
#(
   parameter int DIV_W  = 8,
   parameter int TOP_W  = 8,
   parameter int HIGH_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  reg_sel_e          sel,
   input  logic [HIGH_W-1:0] wdata,
   input  logic              apply,
   output logic [DIV_W-1:0]  stg_div,
   output logic [TOP_W-1:0]  stg_top,
   output logic [HIGH_W-1:0] stg_high,
   output logic              run,
   output logic [DIV_W-1:0]  pnd_div,
   output logic [TOP_W-1:0]  pnd_top,
   output logic [HIGH_W-1:0] pnd_high,
   output logic              pnd_vld
);
   logic commit_wr;
   assign commit_wr = wr && (sel == SEL_HIGH);

   // Staged registers as seen by software.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stg_div  <= '0;
         stg_top  <= '0;
         stg_high <= '0;
         run      <= 1'b0;
      end else if (wr) begin
         case (sel)
            SEL_DIV:  stg_div  <= wdata[DIV_W-1:0];
            SEL_TOP:  stg_top  <= wdata[TOP_W-1:0];
            SEL_HIGH: stg_high <= wdata;
            SEL_RUN:  run      <= wdata[0];
            default:  ;
         endcase
      end
   end

   // Pending set: frozen at the HIGH write, consumed at a boundary.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pnd_div  <= '0;
         pnd_top  <= '0;
         pnd_high <= '0;
         pnd_vld  <= 1'b0;
      end else begin
         if (commit_wr) begin
            pnd_div  <= stg_div;
            pnd_top  <= stg_top;
            pnd_high <= wdata;
         end
         if (commit_wr)
            pnd_vld <= 1'b1;
         else if (apply)
            pnd_vld <= 1'b0;
      end
   end

endmodule

// File: rtl/mpwm_chan_engine.sv
module mpwm_chan_engine #(
   parameter int DIV_W  = 8,
   parameter int TOP_W  = 8,
   parameter int HIGH_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic              pnd_vld,
   input  logic [DIV_W-1:0]  pnd_div,
   input  logic [TOP_W-1:0]  pnd_top,
   input  logic [HIGH_W-1:0] pnd_high,
   output logic              apply,
   output logic              pwm
);
   localparam int CMP_W = (TOP_W > HIGH_W) ? TOP_W : HIGH_W;

   logic [DIV_W-1:0]  act_div;
   logic [TOP_W-1:0]  act_top;
   logic [HIGH_W-1:0] act_high;
   logic [DIV_W-1:0]  pre_cnt;
   logic [TOP_W-1:0]  step;
   logic              tick, last_step, wrap;

   assign tick      = (pre_cnt == act_div);
   assign last_step = (act_top == '0) || (step == act_top - TOP_W'(1));
   assign wrap      = run && tick && last_step;
   assign apply     = pnd_vld && (!run || wrap);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_div  <= '0;
         act_top  <= '0;
         act_high <= '0;
      end else if (apply) begin
         act_div  <= pnd_div;
         act_top  <= pnd_top;
         act_high <= pnd_high;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pre_cnt <= '0;
         step    <= '0;
      end else if (!run || wrap) begin
         pre_cnt <= '0;
         step    <= '0;
      end else if (tick) begin
         pre_cnt <= '0;
         step    <= step + TOP_W'(1);
      end else begin
         pre_cnt <= pre_cnt + DIV_W'(1);
      end
   end

   assign pwm = run && (act_top != '0) && (CMP_W'(step) < CMP_W'(act_high));

endmodule

// File: rtl/mpwm_ctrl.sv
module mpwm_ctrl
   import mpwm_pkg::*;
#(
   parameter int NUM_CH = 4,
   parameter int ADDR_W = 8,
   parameter int DATA_W = 32,
   parameter int DIV_W  = 8,
   parameter int TOP_W  = 8,
   parameter int HIGH_W = 16,
   parameter bit RD_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic              bus_we,
   input  logic              bus_re,
   output logic [DATA_W-1:0] bus_rdata,
   output logic [NUM_CH-1:0] pwm_out
);
   localparam int CH_IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

   // Elaboration-time parameter checks
   if (NUM_CH < 1) begin : g_bad_ch
      $error("mpwm_ctrl: NUM_CH must be at least 1");
   end
   if (ADDR_W < int'(WIN_SHIFT) + CH_IDX_W) begin : g_bad_addr
      $error("mpwm_ctrl: ADDR_W too narrow for NUM_CH windows");
   end
   if (HIGH_W < DIV_W || HIGH_W < TOP_W) begin : g_bad_w
      $error("mpwm_ctrl: HIGH_W must cover DIV_W and TOP_W");
   end
   if (DATA_W < HIGH_W) begin : g_bad_data
      $error("mpwm_ctrl: DATA_W must cover HIGH_W");
   end

   logic [NUM_CH-1:0]   ch_we;
   logic [CH_IDX_W-1:0] dec_idx;
   reg_sel_e            dec_sel;
   logic                dec_hit;
   logic [HIGH_W-1:0]   wdata_eff;

   logic [DIV_W-1:0]  stg_div  [NUM_CH];
   logic [TOP_W-1:0]  stg_top  [NUM_CH];
   logic [HIGH_W-1:0] stg_high [NUM_CH];
   logic [NUM_CH-1:0] ch_run;
   logic [DIV_W-1:0]  pnd_div  [NUM_CH];
   logic [TOP_W-1:0]  pnd_top  [NUM_CH];
   logic [HIGH_W-1:0] pnd_high [NUM_CH];
   logic [NUM_CH-1:0] pnd_vld;
   logic [NUM_CH-1:0] ch_apply;
   logic [DATA_W-1:0] rd_val;

   assign wdata_eff = bus_wdata[HIGH_W-1:0];

   if (DATA_W > HIGH_W) begin : g_wpad
      logic unused_wpad;
      assign unused_wpad = ^bus_wdata[DATA_W-1:HIGH_W];
   end

   mpwm_addr_dec #(
      .NUM_CH   (NUM_CH),
      .ADDR_W   (ADDR_W),
      .CH_IDX_W (CH_IDX_W)
   ) u_dec (
      .addr   (bus_addr),
      .we     (bus_we),
      .ch_we  (ch_we),
      .ch_idx (dec_idx),
      .sel    (dec_sel),
      .hit    (dec_hit)
   );

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      mpwm_chan_regs #(
         .DIV_W  (DIV_W),
         .TOP_W  (TOP_W),
         .HIGH_W (HIGH_W)
      ) u_regs (
         .clk      (clk),
         .rst_n    (rst_n),
         .wr       (ch_we[c]),
         .sel      (dec_sel),
         .wdata    (wdata_eff),
         .apply    (ch_apply[c]),
         .stg_div  (stg_div[c]),
         .stg_top  (stg_top[c]),
         .stg_high (stg_high[c]),
         .run      (ch_run[c]),
         .pnd_div  (pnd_div[c]),
         .pnd_top  (pnd_top[c]),
         .pnd_high (pnd_high[c]),
         .pnd_vld  (pnd_vld[c])
      );

      mpwm_chan_engine #(
         .DIV_W  (DIV_W),
         .TOP_W  (TOP_W),
         .HIGH_W (HIGH_W)
      ) u_eng (
         .clk      (clk),
         .rst_n    (rst_n),
         .run      (ch_run[c]),
         .pnd_vld  (pnd_vld[c]),
         .pnd_div  (pnd_div[c]),
         .pnd_top  (pnd_top[c]),
         .pnd_high (pnd_high[c]),
         .apply    (ch_apply[c]),
         .pwm      (pwm_out[c])
      );
   end

   // Read multiplexer; unmapped addresses decode to SEL_NONE.
   always_comb begin
      rd_val = '0;
      if (dec_hit) begin
         case (dec_sel)
            SEL_DIV:  rd_val = DATA_W'(stg_div[dec_idx]);
            SEL_TOP:  rd_val = DATA_W'(stg_top[dec_idx]);
            SEL_HIGH: rd_val = DATA_W'(stg_high[dec_idx]);
            SEL_RUN:  rd_val = DATA_W'(ch_run[dec_idx]);
            default:  rd_val = '0;
         endcase
      end
   end

   if (RD_REG) begin : g_rd_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            bus_rdata <= '0;
         else if (bus_re)
            bus_rdata <= rd_val;
      end
   end else begin : g_rd_comb
      assign bus_rdata = bus_re ? rd_val : '0;
   end

endmodule

// File: rtl/mpwm_ctrl_chk.sv
module mpwm_ctrl_chk
   import mpwm_pkg::*;
#(
   parameter int NUM_CH = 4,
   parameter int ADDR_W = 8,
   parameter int DATA_W = 32,
   parameter int HIGH_W = 16,
   parameter bit RD_REG = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [DATA_W-1:0] bus_wdata,
   input logic              bus_we,
   input logic              bus_re,
   input logic [DATA_W-1:0] bus_rdata,
   input logic [NUM_CH-1:0] pwm_out
);
   localparam int HI_W = ADDR_W - WIN_SHIFT;

   logic [HI_W-1:0]      c_win;
   logic [WIN_SHIFT-1:0] c_ofs;
   logic                 ofs_map, win_map, mapped;
   logic [NUM_CH-1:0]    run_sh;
   logic                 unused_chk_wdata;

   assign c_win   = bus_addr[ADDR_W-1:WIN_SHIFT];
   assign c_ofs   = bus_addr[WIN_SHIFT-1:0];
   assign ofs_map = (c_ofs == OFS_DIV) || (c_ofs == OFS_TOP) ||
                    (c_ofs == OFS_HIGH) || (c_ofs == OFS_RUN);
   assign win_map = (32'(c_win) < NUM_CH);
   assign mapped  = ofs_map && win_map;
   assign unused_chk_wdata = ^bus_wdata[DATA_W-1:1];

   // Independent shadow of every channel's run bit, built from bus traffic.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         run_sh <= '0;
      else
         for (int c = 0; c < NUM_CH; c++)
            if (bus_we && win_map && (32'(c_win) == c) && (c_ofs == OFS_RUN))
               run_sh[c] <= bus_wdata[0];
   end

   // R11
   reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (pwm_out == '0));

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch_chk
      // R8
      idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !run_sh[c] |-> !pwm_out[c]);

      // R7
      stop_now_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (bus_we && win_map && (32'(c_win) == c) && (c_ofs == OFS_RUN) && !bus_wdata[0])
         |=> !pwm_out[c]);
   end

   if (RD_REG) begin : g_rd_chk
      // R2
      unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (bus_re && !mapped) |=> (bus_rdata == '0));

      // R1
      run_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (bus_re && mapped && (c_ofs == OFS_RUN)) |=> (bus_rdata[DATA_W-1:1] == '0));

      if (DATA_W > HIGH_W) begin : g_pad_chk
         // R1
         pad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_re && mapped) |=> (bus_rdata[DATA_W-1:HIGH_W] == '0));
      end
   end

endmodule

bind mpwm_ctrl mpwm_ctrl_chk #(
   .NUM_CH (NUM_CH),
   .ADDR_W (ADDR_W),
   .DATA_W (DATA_W),
   .HIGH_W (HIGH_W),
   .RD_REG (RD_REG)
) u_mpwm_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .bus_we    (bus_we),
   .bus_re    (bus_re),
   .bus_rdata (bus_rdata),
   .pwm_out   (pwm_out)
);

// File: tb/mpwm_ctrl_bench.sv
module mpwm_ctrl_bench;

   localparam logic [4:0] O_DIV  = 5'h00;
   localparam logic [4:0] O_TOP  = 5'h04;
   localparam logic [4:0] O_HIGH = 5'h08;
   localparam logic [4:0] O_RUN  = 5'h18;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic        bus_we = 1'b0;
   logic        bus_re = 1'b0;
   logic [31:0] bus_rdata;
   logic [3:0]  pwm_out;

   int n_chk = 0;
   int n_fail = 0;
   int unsigned cyc = 0;
   int unsigned t_en [4];
   bit done = 1'b0;

   always #5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   mpwm_ctrl u_mpwm_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_we    (bus_we),
      .bus_re    (bus_re),
      .bus_rdata (bus_rdata),
      .pwm_out   (pwm_out)
   );

   function automatic logic [7:0] ad(input int ch, input logic [4:0] ofs);
      return 8'((ch << 5) | int'(ofs));
   endfunction

   // Expected level at cycle j of a run: period TOP steps of DIV+1 clocks.
   function automatic bit lvl(input int j, input int dv, input int tp, input int hg);
      if (tp == 0) return 1'b0;
      return ((j / (dv + 1)) % tp) < hg;
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wr_raw(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_we = 1'b1;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic wr(input int ch, input logic [4:0] ofs, input logic [31:0] d);
      wr_raw(ad(ch, ofs), d);
   endtask

   task automatic rd_raw(input logic [7:0] a, input logic [31:0] exp, input string req);
      @(negedge clk);
      bus_addr = a; bus_re = 1'b1;
      @(negedge clk);
      bus_re = 1'b0;
      chk(bus_rdata == exp, req, int'(bus_rdata), int'(exp));
   endtask

   task automatic cfg(input int ch, input int dv, input int tp, input int hg);
      wr(ch, O_RUN, 0);
      wr(ch, O_DIV, dv);
      wr(ch, O_TOP, tp);
      wr(ch, O_HIGH, hg);
   endtask

   task automatic enable(input int ch);
      wr(ch, O_RUN, 1);
      t_en[ch] = cyc;
   endtask

   // Run channel with set A, stage set B from cycle js, optionally commit it.
   task automatic drive_check(input int ch,
                              input int adv, input int atp, input int ahg,
                              input int bdv, input int btp, input int bhg,
                              input int js, input bit commit, input int extra,
                              input int n, input string req);
      int pa, jh, bnd;
      bit e;
      cfg(ch, adv, atp, ahg);
      enable(ch);
      pa  = (atp == 0) ? (adv + 1) : atp * (adv + 1);
      jh  = (extra >= 0) ? js + 3 : js + 2;
      bnd = commit ? ((jh + 2 + pa - 1) / pa) * pa : 32'h7fff_ffff;
      for (int j = 0; j < n; j++) begin
         e = (j >= bnd) ? lvl(j - bnd, bdv, btp, bhg) : lvl(j, adv, atp, ahg);
         chk(pwm_out[ch] == e, req, int'(pwm_out[ch]), int'(e));
         bus_we = 1'b0;
         if (j == js) begin
            bus_addr = ad(ch, O_DIV); bus_wdata = bdv; bus_we = 1'b1;
         end else if (j == js + 1) begin
            bus_addr = ad(ch, O_TOP); bus_wdata = btp; bus_we = 1'b1;
         end else if (j == js + 2 && extra >= 0) begin
            bus_addr = ad(ch, O_HIGH); bus_wdata = extra; bus_we = 1'b1;
         end else if (j == jh && commit) begin
            bus_addr = ad(ch, O_HIGH); bus_wdata = bhg; bus_we = 1'b1;
         end
         @(negedge clk);
      end
      bus_we = 1'b0;
      wr(ch, O_RUN, 0);
   endtask

   task automatic check_wave(input int ch, input int dv, input int tp, input int hg,
                             input int n, input string req);
      for (int j = 0; j < n; j++) begin
         chk(pwm_out[ch] == lvl(j, dv, tp, hg), req, int'(pwm_out[ch]),
             int'(lvl(j, dv, tp, hg)));
         @(negedge clk);
      end
   endtask

   // R11: quiet state after reset
   task automatic t_reset();
      chk(pwm_out == 4'b0, "R11 outputs", int'(pwm_out), 0);
      rd_raw(ad(0, O_DIV), 0, "R11 div");
      rd_raw(ad(0, O_TOP), 0, "R11 top");
      rd_raw(ad(3, O_HIGH), 0, "R11 high");
      rd_raw(ad(3, O_RUN), 0, "R11 run");
   endtask

   // R2: unmapped accesses
   task automatic t_unmapped();
      wr_raw(ad(1, 5'h0C), 32'hFF);
      wr_raw(ad(0, 5'h02), 32'hFF);
      wr_raw(ad(5, O_DIV), 32'h77);
      wr_raw(ad(5, O_RUN), 32'h1);
      wr_raw(ad(5, O_HIGH), 32'h9);
      rd_raw(ad(5, O_DIV), 0, "R2 high window read");
      rd_raw(ad(1, 5'h0C), 0, "R2 hole read");
      rd_raw(ad(0, 5'h02), 0, "R2 misaligned read");
      rd_raw(ad(1, O_DIV), 0, "R2 alias div untouched");
      rd_raw(ad(1, O_RUN), 0, "R2 alias run untouched");
      rd_raw(ad(1, O_HIGH), 0, "R2 alias high untouched");
      repeat (3) @(negedge clk);
      chk(pwm_out == 4'b0, "R2 outputs quiet", int'(pwm_out), 0);
   endtask

   // R1: register map and width
   task automatic t_regmap();
      wr(2, O_DIV, 32'hFFFF_FF5A);
      wr(2, O_TOP, 32'h1234_563C);
      wr(2, O_HIGH, 32'h1234_BEEF);
      wr(2, O_RUN, 32'hFFFF_FFFF);
      rd_raw(ad(2, O_DIV), 32'h5A, "R1 div");
      rd_raw(ad(2, O_TOP), 32'h3C, "R1 top");
      rd_raw(ad(2, O_HIGH), 32'hBEEF, "R1 high");
      rd_raw(ad(2, O_RUN), 32'h1, "R1 run");
      wr(2, O_RUN, 0);
      rd_raw(ad(2, O_RUN), 32'h0, "R1 run clear");
   endtask

   // R7: immediate stop, then restart from step 0
   task automatic t_stop();
      bit e;
      cfg(0, 1, 6, 4);
      enable(0);
      for (int j = 0; j < 12; j++) begin
         e = (j < 4) ? lvl(j, 1, 6, 4) : 1'b0;
         chk(pwm_out[0] == e, "R7 stop", int'(pwm_out[0]), int'(e));
         bus_we = 1'b0;
         if (j == 3) begin
            bus_addr = ad(0, O_RUN); bus_wdata = 0; bus_we = 1'b1;
         end
         @(negedge clk);
      end
      bus_we = 1'b0;
      enable(0);
      check_wave(0, 1, 6, 4, 24, "R7 restart");
      wr(0, O_RUN, 0);
   endtask

   // R8: commit while disabled
   task automatic t_idle_commit();
      cfg(2, 0, 4, 2);
      wr(2, O_HIGH, 3);
      for (int j = 0; j < 8; j++) begin
         chk(pwm_out[2] == 1'b0, "R8 idle low", int'(pwm_out[2]), 0);
         @(negedge clk);
      end
      enable(2);
      check_wave(2, 0, 4, 3, 12, "R8 latest commit");
      wr(2, O_RUN, 0);
   endtask

   // R12: two channels at once
   task automatic t_multi();
      int j1, j3;
      cfg(1, 0, 3, 1);
      enable(1);
      cfg(3, 1, 4, 3);
      enable(3);
      for (int k = 0; k < 24; k++) begin
         j1 = int'(cyc - t_en[1]);
         j3 = int'(cyc - t_en[3]);
         chk(pwm_out[1] == lvl(j1, 0, 3, 1), "R12 ch1", int'(pwm_out[1]),
             int'(lvl(j1, 0, 3, 1)));
         chk(pwm_out[3] == lvl(j3, 1, 4, 3), "R12 ch3", int'(pwm_out[3]),
             int'(lvl(j3, 1, 4, 3)));
         chk(pwm_out[0] == 1'b0 && pwm_out[2] == 1'b0, "R12 idle channels",
             int'(pwm_out), 0);
         @(negedge clk);
      end
      wr(1, O_RUN, 0);
      wr(3, O_RUN, 0);
   endtask

   initial begin : watchdog
      repeat (60000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=hung expected=finish");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin : main
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_unmapped();
      t_regmap();
      // R3: timing under several patterns
      drive_check(0, 1, 5, 2, 0, 0, 0, 100, 1'b0, -1, 30, "R3 div1 top5 high2");
      drive_check(0, 0, 4, 3, 0, 0, 0, 100, 1'b0, -1, 16, "R3 div0 top4 high3");
      drive_check(1, 2, 3, 1, 0, 0, 0, 100, 1'b0, -1, 27, "R3 div2 top3 high1");
      // R4: staging only
      drive_check(0, 1, 5, 2, 0, 2, 1, 2, 1'b0, -1, 30, "R4 staged only");
      // R5: commit at boundary with new prescale, early and late in period
      drive_check(0, 1, 5, 2, 0, 3, 2, 2, 1'b1, -1, 34, "R5 early commit");
      drive_check(0, 1, 5, 2, 2, 2, 1, 6, 1'b1, -1, 34, "R5 commit just in time");
      drive_check(0, 1, 5, 2, 0, 3, 2, 7, 1'b1, -1, 44, "R5 commit just late");
      // R6: second commit replaces pending set
      drive_check(0, 1, 5, 2, 0, 3, 1, 2, 1'b1, 4, 34, "R6 replaced pending");
      // R9: saturated and zero duty
      drive_check(1, 0, 4, 4, 0, 0, 0, 100, 1'b0, -1, 12, "R9 high equals top");
      drive_check(1, 1, 3, 200, 0, 0, 0, 100, 1'b0, -1, 12, "R9 high above top");
      drive_check(1, 0, 5, 0, 0, 0, 0, 100, 1'b0, -1, 12, "R9 zero high");
      // R10: zero period, commit taken at a prescale tick
      drive_check(3, 2, 0, 5, 0, 4, 2, 2, 1'b1, -1, 24, "R10 zero top");
      t_stop();
      t_idle_commit();
      t_multi();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule